// File: doc/BRIEF.md
# Oversampled Asynchronous Flash Bus Front-End

This block sits between the asynchronous pins of a parallel flash-style bus and the synchronous logic behind them. A fast sampling clock watches three active-low strobes: chip select, output enable and write strobe. Each strobe passes through a run-length glitch filter, so short spikes never reach the rest of the design. The block also tracks the address and data pins.

A bus write is the window in which chip select and the write strobe are both asserted. The write address is taken when that window opens. The write data is taken when it closes. A one-cycle event then reports the address and data to the command logic. A bus read is reported as a level. While a read is active, the block drives a per-bit output-enable vector for the data pins.

In the narrow (x8) organisation, the top data pin acts as the lowest address bit. Only the low half of the data pins is ever driven in that mode. A quiet-bus timer raises a standby flag after a run of unchanged samples. That flag does not stop a read that is already driving data.

Top module: `flash_bus_frontend`

## Requirements
- R1: While rst_ni is low, wr_evt_o, dq_oe_o, rd_active_o and standby_o are all zero.
- R2: A strobe level is accepted only after FILT_LEN (5) consecutive samples at that level. A write-strobe low pulse of 4 samples gives no write event. A pulse of 5 samples gives one.
- R3: The write address comes from the pin state one sample before the later of the two assertions (chip select or write strobe going low). Address changes before that point and after it do not affect the captured address.
- R4: The write data comes from the pin state one sample before the earlier of the two deassertions. Data changed after that deassertion does not affect wr_data_o.
- R5: While chip select is high, no write event occurs and dq_oe_o stays zero, whatever the other strobes do.
- R6: dq_oe_o is zero while output enable is high. It is nonzero while chip select and output enable are low and the write strobe is high.
- R7: A write event is produced only if output enable was high when the write window closed.
- R8: With word_mode_i low (x8), the address LSB of wr_addr_o and rd_addr_o is dq_i[15]. wr_data_o is {8'h00, dq_i[7:0]}, and during a read dq_oe_o is 16'h00FF. With word_mode_i high, the LSB is 0, the full 16 bits are used, and a read drives 16'hFFFF.
- R9: wr_evt_o is high for exactly one clock per accepted write.
- R10: standby_o rises after IDLE_CYC (300) samples with no change on any input pin. An active read keeps its dq_oe_o value while in standby. Any pin change clears standby on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, one period per filter sample |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| word_mode_i | input | 1 | 1: x16 organisation, 0: x8 organisation |
| addr_i | input | AW | Address pins |
| dq_i | input | DW | Data pins as seen at the input buffers |
| dq_oe_o | output | DW | Per-bit output enable for the data pins |
| rd_active_o | output | 1 | Filtered bus-read condition |
| rd_addr_o | output | AW+1 | Read address with byte-lane LSB |
| wr_evt_o | output | 1 | One-clock pulse for each accepted bus write |
| wr_addr_o | output | AW+1 | Captured write address with byte-lane LSB |
| wr_data_o | output | DW | Captured write data |
| standby_o | output | 1 | Bus has been quiet for IDLE_CYC samples |

## Verification
Several properties are checked on every cycle. A filtered strobe may only move to a level the raw pin showed on the previous sample. A write event needs output enable high and never lasts two cycles. The upper data lanes are never enabled in x8 mode. A pin change always clears standby.

Other behaviour can only be shown by the bench scenarios. These are the exact capture points for address and data when the two strobes fall and rise in either order, the 4-versus-5 sample glitch boundary, the suppression of writes while chip select is high or output enable is low, and the standby threshold during a held read.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum int unsigned {
    STB_CE = 0,
    STB_OE = 1,
    STB_WE = 2
  } stb_idx_e;
  localparam int unsigned NUM_STB = 3;
endpackage

// File: rtl/fbf_glitch_filter.sv
module fbf_glitch_filter #(
  parameter int unsigned LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      filt_q <= 1'b1;
    end else if (raw_i == filt_q) begin
      run_q <= '0;
    end else if (run_q == CW'(LEN - 1)) begin
      filt_q <= raw_i;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  a_r2_flip_follows_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_o != $past(filt_o)) |-> ($past(raw_i) == filt_o));
endmodule

// File: rtl/fbf_delay.sv
module fbf_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/fbf_idle_timer.sv
module fbf_idle_timer #(
  parameter int unsigned W        = 8,
  parameter int unsigned IDLE_CYC = 300
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_i,
  output logic         standby_o
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] quiet_q;
  logic          chg;

  assign chg = (bus_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      quiet_q <= '0;
    end else begin
      prev_q <= bus_i;
      if (chg) quiet_q <= '0;
      else if (quiet_q != CW'(IDLE_CYC)) quiet_q <= quiet_q + 1'b1;
    end
  end

  assign standby_o = (quiet_q == CW'(IDLE_CYC));

  a_r10_change_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> !standby_o);
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend #(
  parameter int unsigned AW       = 22,
  parameter int unsigned DW       = 16,
  parameter int unsigned FILT_LEN = 5,
  parameter int unsigned IDLE_CYC = 300
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          word_mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_oe_o,
  output logic          rd_active_o,
  output logic [AW:0]   rd_addr_o,
  output logic          wr_evt_o,
  output logic [AW:0]   wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          standby_o
);
  import fbf_pkg::*;

  localparam int unsigned HW  = DW / 2;
  localparam int unsigned PW  = 1 + AW + DW;
  localparam int unsigned BW  = 4 + AW + DW;
  localparam int unsigned DLY = FILT_LEN + 1;

  // strobe filtering
  logic [NUM_STB-1:0] stb_raw, stb_f;
  assign stb_raw[STB_CE] = ce_ni;
  assign stb_raw[STB_OE] = oe_ni;
  assign stb_raw[STB_WE] = we_ni;

  for (genvar i = 0; i < NUM_STB; i++) begin : g_flt
    fbf_glitch_filter #(.LEN(FILT_LEN)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (stb_raw[i]),
      .filt_o(stb_f[i])
    );
  end

  logic ce_f, oe_f, we_f;
  assign ce_f = stb_f[STB_CE];
  assign oe_f = stb_f[STB_OE];
  assign we_f = stb_f[STB_WE];

  // pin delay aligned with the filter latency
  logic [PW-1:0] dly;
  fbf_delay #(.W(PW), .DEPTH(DLY)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({word_mode_i, addr_i, dq_i}),
    .q_o   (dly)
  );

  logic          d_word;
  logic [AW-1:0] d_addr;
  logic [DW-1:0] d_dq;
  assign {d_word, d_addr, d_dq} = dly;

  // write window
  logic          wr_win, wr_win_q, wr_evt_q;
  logic [AW:0]   wr_addr_q;
  logic [DW-1:0] wr_data_q;

  assign wr_win = ~ce_f & ~we_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_win_q  <= 1'b0;
      wr_evt_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_win_q <= wr_win;
      wr_evt_q <= 1'b0;
      if (wr_win && !wr_win_q)
        wr_addr_q <= {d_addr, d_word ? 1'b0 : d_dq[DW-1]};
      if (!wr_win && wr_win_q) begin
        wr_data_q <= d_word ? d_dq : {{(DW-HW){1'b0}}, d_dq[HW-1:0]};
        wr_evt_q  <= oe_f;
      end
    end
  end

  assign wr_evt_o  = wr_evt_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  // read path
  assign rd_active_o = ~ce_f & ~oe_f & we_f;
  assign rd_addr_o   = {addr_i, word_mode_i ? 1'b0 : dq_i[DW-1]};

  for (genvar b = 0; b < DW; b++) begin : g_oe
    if (b < HW) begin : g_lo
      assign dq_oe_o[b] = rd_active_o;
    end else begin : g_hi
      assign dq_oe_o[b] = rd_active_o & word_mode_i;
    end
  end

  fbf_idle_timer #(.W(BW), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_i    ({ce_ni, oe_ni, we_ni, word_mode_i, addr_i, dq_i}),
    .standby_o(standby_o)
  );

  a_r7_evt_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_o |-> $past(oe_f));
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_o |=> !wr_evt_o);
  a_r8_upper_lanes_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dq_oe_o[DW-1:HW]) |-> word_mode_i);
  a_r5_no_drive_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_f) && ce_f |-> (dq_oe_o == '0));
endmodule

// File: tb/flash_bus_frontend_tb.sv
`timescale 1ns/1ps
module flash_bus_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int DW = 16;

  typedef struct packed {
    logic          wm;
    logic          ce_fall_first;
    logic          ce_rise_first;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } wvec_t;

  localparam int NV = 6;
  localparam wvec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 22'h012345, 16'hA5C3},
    '{1'b1, 1'b0, 1'b0, 22'h3FFFFF, 16'h0001},
    '{1'b1, 1'b1, 1'b0, 22'h000000, 16'hFFFF},
    '{1'b0, 1'b0, 1'b1, 22'h2AAAAA, 16'h805A},
    '{1'b0, 1'b1, 1'b0, 22'h155555, 16'h7F81},
    '{1'b0, 1'b0, 1'b0, 22'h0F0F0F, 16'hC33C}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, word_mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq = '0;
  logic [DW-1:0] dq_oe_o, wr_data_o;
  logic rd_active_o, wr_evt_o, standby_o;
  logic [AW:0] rd_addr_o, wr_addr_o;

  int checks = 0, errors = 0, evt_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .word_mode_i(word_mode), .addr_i(addr), .dq_i(dq),
    .dq_oe_o(dq_oe_o), .rd_active_o(rd_active_o), .rd_addr_o(rd_addr_o),
    .wr_evt_o(wr_evt_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .standby_o(standby_o)
  );

  always @(negedge clk) if (rst_ni && wr_evt_o) evt_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input wvec_t v, input int idx);
    int base;
    logic [AW:0] exp_a;
    logic [DW-1:0] exp_d;
    exp_a = {v.a, v.wm ? 1'b0 : v.d[DW-1]};
    exp_d = v.wm ? v.d : {8'h00, v.d[7:0]};
    @(negedge clk);
    word_mode = v.wm; oe_ni = 1'b1; addr = ~v.a; dq = v.d;
    wait_n(8);
    base = evt_cnt;
    if (v.ce_fall_first) ce_ni = 1'b0; else we_ni = 1'b0;
    wait_n(8);
    addr = v.a;                      // only valid around the later fall
    wait_n(2);
    if (v.ce_fall_first) we_ni = 1'b0; else ce_ni = 1'b0;
    wait_n(8);
    addr = ~v.a;
    wait_n(4);
    if (v.ce_rise_first) ce_ni = 1'b1; else we_ni = 1'b1;
    @(negedge clk);
    dq = ~v.d;                       // after the earlier rise
    wait_n(8);
    ce_ni = 1'b1; we_ni = 1'b1;
    wait_n(12);
    chk($sformatf("R9 vec%0d event count", idx), 64'(evt_cnt - base), 64'd1);
    chk($sformatf("R3 vec%0d address", idx), 64'(wr_addr_o), 64'(exp_a));
    chk($sformatf("R4 vec%0d data", idx), 64'(wr_data_o), 64'(exp_d));
    if (!v.wm) chk($sformatf("R8 vec%0d byte lsb", idx), 64'(wr_addr_o[0]), 64'(v.d[DW-1]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    wait_n(5);
    // R1: reset values
    chk("R1 wr_evt", 64'(wr_evt_o), 0);
    chk("R1 dq_oe", 64'(dq_oe_o), 0);
    chk("R1 rd_active", 64'(rd_active_o), 0);
    chk("R1 standby", 64'(standby_o), 0);
    rst_ni = 1'b1;
    wait_n(4);

    for (int i = 0; i < NV; i++) do_write(VECS[i], i);

    // R2: glitch boundary on write strobe
    word_mode = 1'b1; dq = 16'h1234; addr = 22'h000100;
    ce_ni = 1'b0; oe_ni = 1'b1; wait_n(8);
    base = evt_cnt;
    we_ni = 1'b0; wait_n(4); we_ni = 1'b1; wait_n(12);
    chk("R2 4-sample pulse rejected", 64'(evt_cnt - base), 0);
    base = evt_cnt;
    we_ni = 1'b0; wait_n(5); we_ni = 1'b1; wait_n(12);
    chk("R2 5-sample pulse accepted", 64'(evt_cnt - base), 1);
    chk("R2 data of accepted pulse", 64'(wr_data_o), 64'h1234);
    ce_ni = 1'b1; wait_n(8);

    // R5: deselected, strobes ignored
    base = evt_cnt;
    oe_ni = 1'b0; we_ni = 1'b0; wait_n(10); we_ni = 1'b1; wait_n(8);
    chk("R5 no event deselected", 64'(evt_cnt - base), 0);
    chk("R5 no drive deselected", 64'(dq_oe_o), 0);
    oe_ni = 1'b1; wait_n(8);

    // R7: write window with output enable low
    base = evt_cnt;
    ce_ni = 1'b0; oe_ni = 1'b0; wait_n(8);
    we_ni = 1'b0; wait_n(10); we_ni = 1'b1; wait_n(12);
    chk("R7 no event with oe low", 64'(evt_cnt - base), 0);
    ce_ni = 1'b1; oe_ni = 1'b1; wait_n(8);

    // R6/R8: word read
    word_mode = 1'b1; addr = 22'h2ABCDE; dq = 16'h8000;
    ce_ni = 1'b0; oe_ni = 1'b0; wait_n(8);
    chk("R6 read active", 64'(rd_active_o), 1);
    chk("R8 word read drive", 64'(dq_oe_o), 64'hFFFF);
    chk("R8 word read addr", 64'(rd_addr_o), 64'({22'h2ABCDE, 1'b0}));
    oe_ni = 1'b1; wait_n(8);
    chk("R6 oe high no drive", 64'(dq_oe_o), 0);

    // R8/R10: byte read held, standby
    word_mode = 1'b0; addr = 22'h001234; dq = 16'h8000; oe_ni = 1'b0;
    @(negedge clk);
    wait_n(290);
    chk("R8 byte read drive", 64'(dq_oe_o), 64'h00FF);
    chk("R8 byte read addr", 64'(rd_addr_o), 64'({22'h001234, 1'b1}));
    chk("R10 not yet standby", 64'(standby_o), 0);
    wait_n(20);
    chk("R10 standby after quiet", 64'(standby_o), 1);
    chk("R10 read still drives", 64'(dq_oe_o), 64'h00FF);
    addr = 22'h001235; wait_n(2);
    chk("R10 change clears standby", 64'(standby_o), 0);
    ce_ni = 1'b1; oe_ni = 1'b1; wait_n(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule